// File: doc/BRIEF.md
# Multi-port PHY interrupt aggregator

This block gathers status-change events from a group of PHY ports and reduces them to one active-low interrupt line shared by all ports. Each port reports three kinds of change as single-cycle pulses: a duplex change, a link change and an isolate change. Every pulse sets a sticky status bit that stays set until software reads it.

The interrupt is gated at two levels. Inside a port, each status bit is qualified by its own enable bit, and the qualified bits are merged into one port request. That request is then qualified by a per-port interrupt enable. A per-port force bit raises the port's request whatever its status and enables are. The requests of all ports are ORed, and the result drives the interrupt pin from a flop.

Software reaches the registers through a simple synchronous read/write port. The register address picks the port and one of three registers: event enable, event status, or control. The control register holds the interrupt enable and the force bit. Reading a status register clears it. The serial management framing and the PHY datapath are outside this block.

Top module: `phy_irq_aggregator`

## Requirements
- R1: After reset the interrupt pin `irq_n_o` is high, `reg_rdata_o` is 0, and every enable, status and control register reads 0.
- R2: An event pulse on `evt_pulse_i` bit `p*NUM_EVENTS+e` sets status bit `e` of port `p`. Event 0 is duplex change, event 1 is link change and event 2 is isolate change. The bit holds until that port's status register is read.
- R3: A read sets `reg_rdata_o` to the addressed register's value one clock after `reg_rd_i`, and the read data then holds until the next read. Reading a status register clears it.
- R4: If an event pulse for a port arrives in the same cycle as a read of that port's status register, the read returns the old value and the new bit stays set afterwards.
- R5: A status bit latches even when its event enable bit is 0. An unenabled bit never drives the interrupt.
- R6: `irq_n_o` is driven low one clock after any port has a status bit set together with its enable bit, while that port's interrupt enable is 1.
- R7: A port whose interrupt enable (control bit 0) is 0 cannot drive the interrupt through its events. Its status bits still latch.
- R8: When a port's force bit (control bit 1) is 1, `irq_n_o` goes low one clock later, whatever that port's status, enables and interrupt enable are.
- R9: Address bits [1:0] select the register: 0 for event enable, 1 for event status, 2 for control, 3 for reserved. The upper address bits select the port. Writes keep only the defined bits: bits [NUM_EVENTS-1:0] of the enable register, and bits 1:0 of the control register. The reserved register reads 0 and ignores writes.
- R10: A write to a status register has no effect. A read of an enable or control register leaves it unchanged.
- R11: `irq_n_o` returns high one clock after the last request is removed, whether by a status read, by clearing an enable, or by clearing a force bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse_i | input | NUM_PORTS*NUM_EVENTS | Event pulses, bit p*NUM_EVENTS+e for event e of port p |
| reg_addr_i | input | PORT_W+2 | Register address: port in the upper bits, register select in [1:0] |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Registered read data |
| irq_n_o | output | 1 | Registered active-low interrupt |

## Verification
A status bit that is lost or that sticks shows up at the ports in two ways. On the next status read of that port, the returned value is wrong. Within one clock of the bit changing, `irq_n_o` takes the wrong level, provided the bit is enabled. A gating fault at either level, or a broken force bit, changes the interrupt level in the very next cycle. For this reason the bench compares `irq_n_o` and `reg_rdata_o` against a reference model on every clock. Directed cases cover a status read in the same cycle as a new event, masked ports, forced ports, and the reserved register.

// File: rtl/phy_irq_pkg.sv
// Package: shared register select codes and control bit positions for the
// PHY interrupt aggregator. Assumes a two-bit register select field.
package phy_irq_pkg;
    typedef enum logic [1:0] {
        SEL_ENABLE  = 2'd0,
        SEL_STATUS  = 2'd1,
        SEL_CONTROL = 2'd2,
        SEL_RSVD    = 2'd3
    } reg_sel_e;

    localparam int CTRL_IE_BIT    = 0;
    localparam int CTRL_FORCE_BIT = 1;
endpackage

// File: rtl/phy_irq_port.sv
// Module: phy_irq_port
// Holds one port's event enable, sticky event status and control bits, and
// computes the port's interrupt request. Assumes the strobes are already
// decoded for this port and that at most one of them is high per cycle.
module phy_irq_port
    import phy_irq_pkg::*;
#(
    parameter int NUM_EVENTS = 3,
    parameter int DATA_W     = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_EVENTS-1:0] evt_i,
    input  logic                  wr_en_i,
    input  logic                  wr_ctl_i,
    input  logic                  rd_stat_i,
    input  logic [DATA_W-1:0]     wdata_i,
    output logic [NUM_EVENTS-1:0] en_o,
    output logic [NUM_EVENTS-1:0] stat_o,
    output logic                  ie_o,
    output logic                  force_o,
    output logic                  req_o
);
    logic [NUM_EVENTS-1:0] en_q;
    logic [NUM_EVENTS-1:0] stat_q;
    logic                  ie_q;
    logic                  force_q;

    // Event enable register, loaded by a write.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '0;
        else if (wr_en_i) en_q <= wdata_i[NUM_EVENTS-1:0];
    end

    // Control register: interrupt enable and force bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q    <= 1'b0;
            force_q <= 1'b0;
        end else if (wr_ctl_i) begin
            ie_q    <= wdata_i[CTRL_IE_BIT];
            force_q <= wdata_i[CTRL_FORCE_BIT];
        end
    end

    // One sticky status bit per event; a new event wins over a clearing read.
    for (genvar e = 0; e < NUM_EVENTS; e++) begin : gen_evt
        always_ff @(posedge clk) begin
            if (!rst_n)         stat_q[e] <= 1'b0;
            else if (evt_i[e])  stat_q[e] <= 1'b1;
            else if (rd_stat_i) stat_q[e] <= 1'b0;
        end

        // R2: an event pulse is latched by the next edge.
        assert_evt_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[e] |=> stat_q[e]);
        // R2: a set bit holds while no read happens.
        assert_evt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_q[e] && !rd_stat_i) |=> stat_q[e]);
        // R3: a read with no new event clears the bit.
        assert_read_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_stat_i && !evt_i[e]) |=> !stat_q[e]);
    end

    // Two-level gating: per event, then per port, with the force override.
    always_comb begin
        req_o = force_q | (ie_q & (|(stat_q & en_q)));
    end

    assign en_o    = en_q;
    assign stat_o  = stat_q;
    assign ie_o    = ie_q;
    assign force_o = force_q;

    // R10: a clearing read does not disturb the enable register.
    assert_en_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(en_q));
endmodule

// File: rtl/phy_irq_rdmux.sv
// Module: phy_irq_rdmux
// Selects the addressed register of the addressed port and registers it on
// a read strobe. Assumes the flattened per-port vectors are ordered with
// port 0 in the low bits. Unused data bits read as zero.
module phy_irq_rdmux
    import phy_irq_pkg::*;
#(
    parameter int NUM_PORTS  = 8,
    parameter int NUM_EVENTS = 3,
    parameter int DATA_W     = 16,
    parameter int PORT_W     = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rd_i,
    input  logic [PORT_W-1:0]               port_i,
    input  reg_sel_e                        sel_i,
    input  logic [NUM_PORTS*NUM_EVENTS-1:0] en_all_i,
    input  logic [NUM_PORTS*NUM_EVENTS-1:0] stat_all_i,
    input  logic [NUM_PORTS-1:0]            ie_all_i,
    input  logic [NUM_PORTS-1:0]            force_all_i,
    output logic [DATA_W-1:0]               rdata_o
);
    logic [DATA_W-1:0] word;
    logic [DATA_W-1:0] rdata_q;

    // Builds the read word for the selected port and register.
    always_comb begin
        word = '0;
        if (int'(port_i) < NUM_PORTS) begin
            case (sel_i)
                SEL_ENABLE:  word[NUM_EVENTS-1:0] = en_all_i[port_i*NUM_EVENTS +: NUM_EVENTS];
                SEL_STATUS:  word[NUM_EVENTS-1:0] = stat_all_i[port_i*NUM_EVENTS +: NUM_EVENTS];
                SEL_CONTROL: begin
                    word[CTRL_IE_BIT]    = ie_all_i[port_i];
                    word[CTRL_FORCE_BIT] = force_all_i[port_i];
                end
                default:     word = '0;
            endcase
        end
    end

    // Read data register, loaded only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    rdata_q <= '0;
        else if (rd_i) rdata_q <= word;
    end

    assign rdata_o = rdata_q;

    // R9: the reserved register reads as zero.
    assert_rsvd_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && sel_i == SEL_RSVD) |=> (rdata_o == '0));
    // R3: read data holds between reads.
    assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/phy_irq_combine.sv
// Module: phy_irq_combine
// ORs the port requests and drives the shared active-low interrupt from a
// flop, so the pin carries no combinational glitches. Assumes the requests
// are synchronous to clk.
module phy_irq_combine #(
    parameter int NUM_PORTS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] req_i,
    input  logic [NUM_PORTS-1:0] force_i,
    output logic                 irq_n_o
);
    logic irq_n_q;

    // Registered wired-OR of all port requests, inverted for active low.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_n_q <= 1'b1;
        else        irq_n_q <= ~(|req_i);
    end

    assign irq_n_o = irq_n_q;

    // R6: any request pulls the pin low one clock later.
    assert_irq_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_i) |=> !irq_n_o);
    // R11: no request releases the pin one clock later.
    assert_irq_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(|req_i) |=> irq_n_o);
    // R8: any force bit pulls the pin low one clock later.
    assert_force_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|force_i) |=> !irq_n_o);
endmodule

// File: rtl/phy_irq_aggregator.sv
// Module: phy_irq_aggregator (top)
// Decodes the register port, instantiates one status/enable slice per PHY
// port, and merges the slices onto one registered active-low interrupt.
// Assumes software does not read and write in the same cycle. If it does,
// the read returns the value from before the write.
module phy_irq_aggregator
    import phy_irq_pkg::*;
#(
    parameter int NUM_PORTS  = 8,
    parameter int NUM_EVENTS = 3,
    parameter int DATA_W     = 16,
    localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int ADDR_W    = PORT_W + 2,
    localparam int EVT_W     = NUM_PORTS * NUM_EVENTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_W-1:0]  evt_pulse_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_n_o
);
    reg_sel_e          sel;
    logic [PORT_W-1:0] port_idx;

    logic [EVT_W-1:0]     en_all;
    logic [EVT_W-1:0]     stat_all;
    logic [NUM_PORTS-1:0] ie_all;
    logic [NUM_PORTS-1:0] force_all;
    logic [NUM_PORTS-1:0] req_all;

    // Splits the address into register select and port index.
    always_comb begin
        sel      = reg_sel_e'(reg_addr_i[1:0]);
        port_idx = reg_addr_i[ADDR_W-1:2];
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : gen_port
        logic hit;
        logic wr_en;
        logic wr_ctl;
        logic rd_stat;

        // Per-port strobe decode.
        always_comb begin
            hit     = (port_idx == PORT_W'(p));
            wr_en   = reg_wr_i & hit & (sel == SEL_ENABLE);
            wr_ctl  = reg_wr_i & hit & (sel == SEL_CONTROL);
            rd_stat = reg_rd_i & hit & (sel == SEL_STATUS);
        end

        phy_irq_port #(
            .NUM_EVENTS (NUM_EVENTS),
            .DATA_W     (DATA_W)
        ) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_i     (evt_pulse_i[p*NUM_EVENTS +: NUM_EVENTS]),
            .wr_en_i   (wr_en),
            .wr_ctl_i  (wr_ctl),
            .rd_stat_i (rd_stat),
            .wdata_i   (reg_wdata_i),
            .en_o      (en_all[p*NUM_EVENTS +: NUM_EVENTS]),
            .stat_o    (stat_all[p*NUM_EVENTS +: NUM_EVENTS]),
            .ie_o      (ie_all[p]),
            .force_o   (force_all[p]),
            .req_o     (req_all[p])
        );
    end

    phy_irq_rdmux #(
        .NUM_PORTS  (NUM_PORTS),
        .NUM_EVENTS (NUM_EVENTS),
        .DATA_W     (DATA_W),
        .PORT_W     (PORT_W)
    ) u_rdmux (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_i        (reg_rd_i),
        .port_i      (port_idx),
        .sel_i       (sel),
        .en_all_i    (en_all),
        .stat_all_i  (stat_all),
        .ie_all_i    (ie_all),
        .force_all_i (force_all),
        .rdata_o     (reg_rdata_o)
    );

    phy_irq_combine #(
        .NUM_PORTS (NUM_PORTS)
    ) u_combine (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_all),
        .force_i (force_all),
        .irq_n_o (irq_n_o)
    );

    // R1: the pin is released right after reset.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> irq_n_o);
endmodule

// File: tb/phy_irq_aggregator_test.sv
`timescale 1ns/1ps
// Bench: directed corner cases followed by seeded random traffic, with every
// cycle compared against a bench-side reference model of the registers.
module phy_irq_aggregator_test;
    localparam int NP = 8;
    localparam int NE = 3;
    localparam int DW = 16;
    localparam int AW = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NP*NE-1:0] evt_pulse = '0;
    logic [AW-1:0]    reg_addr = '0;
    logic             reg_wr = 1'b0;
    logic             reg_rd = 1'b0;
    logic [DW-1:0]    reg_wdata = '0;
    logic [DW-1:0]    reg_rdata;
    logic             irq_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [NE-1:0] m_en [NP];
    logic [NE-1:0] m_st [NP];
    bit            m_ie [NP];
    bit            m_fr [NP];
    logic          exp_irq_n = 1'b1;
    logic [DW-1:0] exp_rdata = '0;

    always #10 clk = ~clk;

    phy_irq_aggregator #(.NUM_PORTS(NP), .NUM_EVENTS(NE), .DATA_W(DW)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_pulse_i (evt_pulse),
        .reg_addr_i  (reg_addr),
        .reg_wr_i    (reg_wr),
        .reg_rd_i    (reg_rd),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .irq_n_o     (irq_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [NP*NE-1:0] ev(input int p, input int e);
        return (NP*NE)'(1) << (p*NE + e);
    endfunction

    function automatic logic [AW-1:0] ad(input int p, input int s);
        return AW'((p << 2) | s);
    endfunction

    function automatic logic [DW-1:0] model_read(input int p, input int s);
        logic [DW-1:0] w = '0;
        case (s)
            0: w[NE-1:0] = m_en[p];
            1: w[NE-1:0] = m_st[p];
            2: begin w[0] = m_ie[p]; w[1] = m_fr[p]; end
            default: w = '0;
        endcase
        return w;
    endfunction

    // One clock: drive at the falling edge, update the model at the rising
    // edge, compare at the next falling edge.
    task automatic cycle(input logic [NP*NE-1:0] evt, input bit wr, input bit rd,
                         input logic [AW-1:0] addr, input logic [DW-1:0] wd);
        bit req;
        int p;
        int s;
        evt_pulse = evt; reg_wr = wr; reg_rd = rd; reg_addr = addr; reg_wdata = wd;
        @(posedge clk);
        req = 1'b0;
        for (int q = 0; q < NP; q++)
            req |= m_fr[q] | (m_ie[q] & (|(m_st[q] & m_en[q])));
        exp_irq_n = !req;
        p = int'(addr[AW-1:2]);
        s = int'(addr[1:0]);
        if (rd) exp_rdata = model_read(p, s);
        if (wr && s == 0) m_en[p] = wd[NE-1:0];
        if (wr && s == 2) begin m_ie[p] = wd[0]; m_fr[p] = wd[1]; end
        for (int q = 0; q < NP; q++) begin
            if (rd && s == 1 && q == p) m_st[q] = '0;
            m_st[q] = m_st[q] | evt[q*NE +: NE];
        end
        @(negedge clk);
        check("R6 R7 R8 R11 irq_n vs model", 32'(irq_n), 32'(exp_irq_n));
        check("R3 rdata vs model", 32'(reg_rdata), 32'(exp_rdata));
    endtask

    task automatic idle();
        cycle('0, 1'b0, 1'b0, '0, '0);
    endtask

    task automatic rd(input int p, input int s);
        cycle('0, 1'b0, 1'b1, ad(p, s), '0);
    endtask

    task automatic wr(input int p, input int s, input logic [DW-1:0] d);
        cycle('0, 1'b1, 1'b0, ad(p, s), d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int q = 0; q < NP; q++) begin
            m_en[q] = '0; m_st[q] = '0; m_ie[q] = 1'b0; m_fr[q] = 1'b0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: idle outputs and all registers zero after reset.
        check("R1 irq_n after reset", 32'(irq_n), 32'd1);
        check("R1 rdata after reset", 32'(reg_rdata), 32'd0);
        for (int p = 0; p < NP; p++)
            for (int s = 0; s < 4; s++) begin
                rd(p, s);
                check("R1 register reads zero", 32'(reg_rdata), 32'd0);
            end

        // R2 and R5: link event latches with enables off; no interrupt.
        wr(3, 2, 16'h0001);
        cycle(ev(3, 1), 1'b0, 1'b0, '0, '0);
        idle();
        check("R5 unenabled event gives no irq", 32'(irq_n), 32'd1);
        rd(3, 1);
        check("R2 link bit latched", 32'(reg_rdata), 32'h2);
        // R3: clear on read.
        rd(3, 1);
        check("R3 status cleared by read", 32'(reg_rdata), 32'h0);

        // R9: only defined bits are kept.
        wr(3, 0, 16'hFFFF);
        rd(3, 0);
        check("R9 enable width", 32'(reg_rdata), 32'h7);
        rd(3, 2);
        check("R9 control readback", 32'(reg_rdata), 32'h1);

        // R6: enabled duplex event drives the pin low one clock after latching.
        cycle(ev(3, 0), 1'b0, 1'b0, '0, '0);
        check("R6 irq still high on latch edge", 32'(irq_n), 32'd1);
        idle();
        check("R6 irq low", 32'(irq_n), 32'd0);
        // R11: reading status releases it one clock later.
        rd(3, 1);
        check("R11 read returns duplex", 32'(reg_rdata), 32'h1);
        check("R11 irq still low on clearing edge", 32'(irq_n), 32'd0);
        idle();
        check("R11 irq released", 32'(irq_n), 32'd1);

        // R4: event in the same cycle as the status read is kept.
        cycle(ev(3, 1), 1'b0, 1'b0, '0, '0);
        cycle(ev(3, 2), 1'b0, 1'b1, ad(3, 1), '0);
        check("R4 read returns old value", 32'(reg_rdata), 32'h2);
        rd(3, 1);
        check("R4 concurrent event kept", 32'(reg_rdata), 32'h4);
        idle();
        idle();

        // R7: port interrupt enable off masks events but status latches.
        wr(3, 2, 16'h0000);
        cycle(ev(3, 1), 1'b0, 1'b0, '0, '0);
        idle();
        idle();
        check("R7 masked port no irq", 32'(irq_n), 32'd1);
        rd(3, 1);
        check("R7 status still latched", 32'(reg_rdata), 32'h2);

        // R8: force with everything else off.
        wr(5, 2, 16'h0002);
        check("R8 not yet forced on write edge", 32'(irq_n), 32'd1);
        idle();
        check("R8 forced irq low", 32'(irq_n), 32'd0);
        wr(5, 2, 16'h0000);
        idle();
        check("R11 irq released after force off", 32'(irq_n), 32'd1);

        // R10: status write ignored; enable read non-destructive.
        cycle(ev(2, 0), 1'b0, 1'b0, '0, '0);
        wr(2, 1, 16'h0000);
        rd(2, 1);
        check("R10 status write ignored", 32'(reg_rdata), 32'h1);
        rd(3, 0);
        rd(3, 0);
        check("R10 enable read non-destructive", 32'(reg_rdata), 32'h7);
        // R9: reserved register.
        wr(4, 3, 16'hFFFF);
        rd(4, 3);
        check("R9 reserved reads zero", 32'(reg_rdata), 32'h0);

        // Seeded random traffic checked against the model every cycle.
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 4000; i++) begin
            logic [NP*NE-1:0] evt = '0;
            int op;
            for (int b = 0; b < NP*NE; b++)
                evt[b] = (($urandom % 20) == 0);
            op = int'($urandom % 10);
            if (op < 4)      cycle(evt, 1'b0, 1'b1, AW'($urandom), '0);
            else if (op < 6) cycle(evt, 1'b1, 1'b0, AW'($urandom), DW'($urandom));
            else             cycle(evt, 1'b0, 1'b0, '0, '0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule